// File: doc/BRIEF.md
# I2C Event Status and Interrupt Unit

This block keeps the status flags and interrupt enables that sit beside an I2C master byte engine. The engine delivers one-cycle pulses when a byte reaches its wait point, when a target fails to acknowledge, when a transfer ends, and when arbitration is lost. Each pulse sets a sticky flag, and the flag stays set until software clears it. The block also tracks a bus-busy level from START and STOP pulses. It brings the raw SCL and SDA pin levels through a synchronizer so that software can read them.

Software reaches two 8-bit registers through one write port and one read port. A select input picks the register. In the status register, writing a 0 to a flag clears that flag and writing a 1 leaves it as it is. Software can therefore acknowledge one event without losing the others. The enable register gates each flag onto a single registered interrupt line. The same register also carries the ninth bit of the SCL low count and the ninth bit of the SCL high count, which are driven out to the clock divider.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset, both registers hold 0 except status bits 7 and 6, which show the synchronized line levels (1 on an idle bus). The interrupt output and both count-extension outputs are 0.
- R2: An event pulse sets its sticky status flag, and the flag reads 1 on the cycle after the pulse and stays 1. The flags are: bit 0 transfer end, bit 1 wait, bit 2 NACK, bit 3 arbitration lost.
- R3: When an event pulse and a software clear of the same flag arrive in the same cycle, the flag ends up set.
- R4: A status write (select 0) clears each flag in bits 3..0 whose data bit is 0. It leaves every flag whose data bit is 1 unchanged.
- R5: Status bit 4 (busy) becomes 1 the cycle after a START pulse and 0 the cycle after a STOP pulse. START wins when both pulses arrive together. Status writes do not change it.
- R6: Status bit 7 shows the SCL input and bit 6 shows the SDA input, each after SYNC_STAGES clock cycles. Status writes do not change them. Status bit 5 always reads 0.
- R7: An enable write (select 1) stores bits 7, 6 and 3..0 and reads them back, while bits 5..4 read 0. Bit 3 enables arbitration lost, bit 2 NACK, bit 1 wait and bit 0 transfer end. Bit 7 drives `scl_low_b8` and bit 6 drives `scl_high_b8`.
- R8: `irq` is a registered OR over bits 3..0 of (flag AND enable). It goes to 1 one cycle after an enabled flag reads 1, and to 0 one cycle after the last enabled flag is cleared or masked.
- R9: While enable bits 3..0 are all 0, `irq` is 0 from the following cycle on, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt_wait | input | 1 | Pulse: byte reached its wait point |
| evt_nack | input | 1 | Pulse: target did not acknowledge |
| evt_xfer_end | input | 1 | Pulse: transfer finished |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| bus_start | input | 1 | Pulse: START condition seen |
| bus_stop | input | 1 | Pulse: STOP condition seen |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| irq | output | 1 | Interrupt request |
| scl_low_b8 | output | 1 | Ninth bit of SCL low count |
| scl_high_b8 | output | 1 | Ninth bit of SCL high count |

## Verification
Register writes, event pulses and START/STOP pulses show up in the read data one edge after they are driven. The interrupt output follows one edge later still, because it is computed from the flags already stored. The line levels take SYNC_STAGES edges, so the bench reads one edge early and expects the old level, then reads at the due edge and expects the new one. Inputs change on the falling edge. Each result is read on a falling edge after the exact number of rising edges counted above, so an extra or a missing register stage fails a check.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
   localparam int REG_W   = 8;
   localparam int N_FLAG  = 4;
   localparam int B_XEND  = 0;
   localparam int B_WAIT  = 1;
   localparam int B_NACK  = 2;
   localparam int B_ARBL  = 3;
   localparam int B_BUSY  = 4;
   localparam int B_SDA   = 6;
   localparam int B_SCL   = 7;
   localparam logic [REG_W-1:0] EN_MASK = 8'hCF;

   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_ENABLE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> q_o);
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/i2c_evt_line_sync.sv
module i2c_evt_line_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else if (STAGES == 1) chain_q[0] <= d_i;
            else chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_evt_irq_comb.sv
module i2c_evt_irq_comb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] en_i,
   output logic         irq_o
);
   logic [N-1:0] hit;
   assign hit = flags_i & en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |hit;
   end

   assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i == '0) |=> !irq_o);
   assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_i == '0) |=> !irq_o);
endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
   import i2c_evt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_LEVEL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             evt_wait,
   input  logic             evt_nack,
   input  logic             evt_xfer_end,
   input  logic             evt_arb_lost,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             irq,
   output logic             scl_low_b8,
   output logic             scl_high_b8
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (REG_W != 8) begin : g_bad_width
         $error("register width must be 8");
      end
   endgenerate

   reg_sel_e          sel;
   logic              wr_status;
   logic              wr_enable;
   logic [N_FLAG-1:0] evt_vec;
   logic [N_FLAG-1:0] flag_q;
   logic [REG_W-1:0]  en_q;
   logic              busy_q;
   logic              scl_s;
   logic              sda_s;
   logic [REG_W-1:0]  status_word;

   assign sel       = reg_sel_e'(reg_sel);
   assign wr_status = reg_wr && (sel == SEL_STATUS);
   assign wr_enable = reg_wr && (sel == SEL_ENABLE);

   always_comb begin
      evt_vec         = '0;
      evt_vec[B_XEND] = evt_xfer_end;
      evt_vec[B_WAIT] = evt_wait;
      evt_vec[B_NACK] = evt_nack;
      evt_vec[B_ARBL] = evt_arb_lost;
   end

   for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
      i2c_evt_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_vec[i]),
         .clr_i (wr_status && !reg_wdata[i]),
         .q_o   (flag_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_enable) en_q <= reg_wdata & EN_MASK;
   end

   assign scl_low_b8  = en_q[7];
   assign scl_high_b8 = en_q[6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_q <= 1'b0;
      else if (bus_start) busy_q <= 1'b1;
      else if (bus_stop)  busy_q <= 1'b0;
   end

   i2c_evt_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVEL)) u_scl_sync (
      .clk (clk), .rst_n (rst_n), .d_i (scl_in), .q_o (scl_s)
   );
   i2c_evt_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVEL)) u_sda_sync (
      .clk (clk), .rst_n (rst_n), .d_i (sda_in), .q_o (sda_s)
   );

   always_comb begin
      status_word                = '0;
      status_word[N_FLAG-1:0]    = flag_q;
      status_word[B_BUSY]        = busy_q;
      status_word[B_SDA]         = sda_s;
      status_word[B_SCL]         = scl_s;
   end

   assign reg_rdata = (sel == SEL_ENABLE) ? en_q : status_word;

   i2c_evt_irq_comb #(.N(N_FLAG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flag_q),
      .en_i    (en_q[N_FLAG-1:0]),
      .irq_o   (irq)
   );

   assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> busy_q);
   assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stop && !bus_start) |=> !busy_q);
   assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_stop && !bus_start) |=> $stable(busy_q));
   assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enable |=> $stable(en_q));
   assert_en_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[5:4] == 2'b00);
endmodule

// File: tb/i2c_evt_irq_unit_tb.sv
module i2c_evt_irq_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       evt_wait = 1'b0, evt_nack = 1'b0, evt_xfer_end = 1'b0, evt_arb_lost = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1;
   logic       irq, scl_low_b8, scl_high_b8;
   int         n_checks = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   i2c_evt_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_wait(evt_wait), .evt_nack(evt_nack), .evt_xfer_end(evt_xfer_end),
      .evt_arb_lost(evt_arb_lost), .bus_start(bus_start), .bus_stop(bus_stop),
      .scl_in(scl_in), .sda_in(sda_in), .irq(irq),
      .scl_low_b8(scl_low_b8), .scl_high_b8(scl_high_b8)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   task automatic wr(logic sel, logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b0, v); chk("R1 status", v, 8'hC0);
      rd(1'b1, v); chk("R1 enable", v, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 b8 pins", {6'd0, scl_low_b8, scl_high_b8}, 8'h00);
   endtask

   task automatic t_set();
      logic [7:0] v;
      evt_wait = 1'b1; tick(); evt_wait = 1'b0;
      rd(1'b0, v); chk("R2 wait bit1", v, 8'hC2);
      evt_xfer_end = 1'b1; tick(); evt_xfer_end = 1'b0;
      rd(1'b0, v); chk("R2 xfer end bit0", v, 8'hC3);
      tick(); tick(); tick();
      rd(1'b0, v); chk("R2 sticky", v, 8'hC3);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      wr(1'b0, 8'hFE);
      rd(1'b0, v); chk("R4 clear bit0 only", v, 8'hC2);
      wr(1'b0, 8'hFF);
      rd(1'b0, v); chk("R4 write ones keeps", v, 8'hC2);
   endtask

   task automatic t_set_wins();
      logic [7:0] v;
      reg_sel = 1'b0; reg_wdata = 8'hF9; reg_wr = 1'b1; evt_nack = 1'b1;
      tick();
      reg_wr = 1'b0; evt_nack = 1'b0;
      rd(1'b0, v); chk("R3 set beats clear", v, 8'hC4);
      evt_arb_lost = 1'b1; tick(); evt_arb_lost = 1'b0;
      rd(1'b0, v); chk("R2 arb lost bit3", v, 8'hCC);
      wr(1'b0, 8'h00);
      rd(1'b0, v); chk("R4 clear all", v, 8'hC0);
   endtask

   task automatic t_busy();
      logic [7:0] v;
      bus_start = 1'b1; tick(); bus_start = 1'b0;
      rd(1'b0, v); chk("R5 busy rises", v, 8'hD0);
      wr(1'b0, 8'h00);
      rd(1'b0, v); chk("R5 write ignored on busy", v, 8'hD0);
      bus_stop = 1'b1; tick(); bus_stop = 1'b0;
      rd(1'b0, v); chk("R5 busy falls", v, 8'hC0);
      bus_start = 1'b1; bus_stop = 1'b1; tick(); bus_start = 1'b0; bus_stop = 1'b0;
      rd(1'b0, v); chk("R5 start wins", v, 8'hD0);
      bus_stop = 1'b1; tick(); bus_stop = 1'b0;
      rd(1'b0, v); chk("R5 busy falls again", v, 8'hC0);
   endtask

   task automatic t_lines();
      logic [7:0] v;
      scl_in = 1'b0; tick();
      rd(1'b0, v); chk("R6 scl not yet", v, 8'hC0);
      tick();
      rd(1'b0, v); chk("R6 scl after sync", v, 8'h40);
      sda_in = 1'b0; tick(); tick();
      rd(1'b0, v); chk("R6 sda after sync", v, 8'h00);
      wr(1'b0, 8'hFF);
      rd(1'b0, v); chk("R6 write ignored on lines", v, 8'h00);
      scl_in = 1'b1; sda_in = 1'b1; tick(); tick();
      rd(1'b0, v); chk("R6 lines back high", v, 8'hC0);
   endtask

   task automatic t_enable();
      logic [7:0] v;
      wr(1'b1, 8'hFF);
      rd(1'b1, v); chk("R7 enable readback", v, 8'hCF);
      chk("R7 b8 pins", {6'd0, scl_low_b8, scl_high_b8}, 8'h03);
      wr(1'b1, 8'h40);
      rd(1'b1, v); chk("R7 enable readback 2", v, 8'h40);
      chk("R7 b8 pins 2", {6'd0, scl_low_b8, scl_high_b8}, 8'h01);
      rd(1'b0, v); chk("R7 status untouched", v, 8'hC0);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(1'b1, 8'h08);
      evt_arb_lost = 1'b1; tick(); evt_arb_lost = 1'b0;
      rd(1'b0, v); chk("R2 arb flag", v, 8'hC8);
      chk("R8 irq not yet", {7'd0, irq}, 8'h00);
      tick();
      chk("R8 irq asserted", {7'd0, irq}, 8'h01);
      evt_wait = 1'b1; tick(); evt_wait = 1'b0;
      wr(1'b0, 8'hF7);
      chk("R8 irq lags clear", {7'd0, irq}, 8'h01);
      tick();
      chk("R8 irq drops", {7'd0, irq}, 8'h00);
      tick();
      chk("R8 disabled flag no irq", {7'd0, irq}, 8'h00);
      wr(1'b1, 8'h02);
      chk("R8 irq after enable lag", {7'd0, irq}, 8'h00);
      tick();
      chk("R8 irq from wait", {7'd0, irq}, 8'h01);
      evt_nack = 1'b1; evt_xfer_end = 1'b1; tick(); evt_nack = 1'b0; evt_xfer_end = 1'b0;
      wr(1'b1, 8'hC0);
      tick();
      chk("R9 masked irq", {7'd0, irq}, 8'h00);
      rd(1'b0, v); chk("R9 flags kept", v, 8'hC7);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_set();
      t_clear();
      t_set_wins();
      t_busy();
      t_lines();
      t_enable();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule